// File: doc/BRIEF.md
# Shared-SRAM Circular FIFO Pointer Bank

This block keeps the pointer and occupancy state for three circular FIFOs. The FIFOs are cut out of one shared SRAM that holds 432 words of 64 bits. The receive FIFO (channel 0) is filled by the network-side handler and drained by the host side. The two transmit FIFOs (channels 1 and 2) run the other way. Each channel keeps a write pointer, a read pointer and a word count over a fixed region. From these it gives the SRAM word address for the next write and the next read, a byte level, and full and empty flags. Both agents take their SRAM address from these outputs. Each push or pop moves exactly one 64-bit word (8 bytes).

A small mode controller selects dual mode, with two transmit FIFOs of 96 words each, or merged mode. In merged mode channel 1 owns both transmit regions as one 192-word FIFO and channel 2 is out of service. Moving between the two modes passes through a one-cycle transition state. During that state both transmit pointer sets are cleared. The three 16-word list regions at the top of the SRAM (words 384 to 431) belong to no FIFO.

Mode controller states:
- DUAL: two-channel operation.
- TO_MERGED: transition state. Transmit state is cleared.
- MERGED: one-channel operation.
- TO_DUAL: transition state. Transmit state is cleared.

Transitions:
- DUAL goes to TO_MERGED when `one_chan_i` is 1.
- TO_MERGED always goes to MERGED.
- MERGED goes to TO_DUAL when `one_chan_i` is 0.
- TO_DUAL always goes to DUAL.

Top module: `fifo_ptr_bank`

## Requirements
- R1: After reset every channel shows level 0, empty=1, full=0 and no error pulses. Write and read addresses sit at the region base: 0 for channel 0, 192 for channel 1 and 288 for channel 2.
- R2: An accepted push advances that channel's write address by one word, and an accepted pop advances its read address by one word. Either one changes the level by 8 bytes, and the change is visible after the next rising edge. Bit i of `push_i`, `pop_i`, `full_o`, `empty_o`, `ovf_o` and `udf_o` belongs to channel i.
- R3: A pointer standing on the last word of its region wraps to the region base on the next advance. In dual mode the last words are 191, 287 and 383.
- R4: A channel is full when its level equals its region size in bytes: 1536 for channel 0 and 768 for each transmit channel in dual mode. A push while full is ignored, and `ovf_o` for that channel is 1 for the cycle after the request.
- R5: A pop while empty is ignored, and `udf_o` for that channel is 1 for the cycle after the request.
- R6: When a push and a pop reach the same channel in one cycle, each is accepted on the current state. Neither full nor empty moves both pointers and leaves the level unchanged. When full, only the pop is taken and `ovf_o` pulses. When empty, only the push is taken and `udf_o` pulses.
- R7: The channels are independent. Requests to one channel never change another channel's addresses, level or flags.
- R8: A change of `one_chan_i` takes the mode controller through the transition state into the new mode on the next two edges. At the second edge both transmit channels return to their base addresses with level 0. Transmit requests made during the transition state are dropped without an error pulse. Channel 0 is not affected.
- R9: In merged mode channel 1 covers words 192 to 383 and holds 1536 bytes. Channel 2 shows full=1, empty=1 and level 0, and any push or pop to it is ignored and raises `ovf_o` or `udf_o`.
- R10: No write or read address ever points into the list area, words 384 to 431.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| one_chan_i | input | 1 | 1 requests merged transmit mode, 0 requests dual mode |
| push_i | input | 3 | Per-channel push request, one word each |
| pop_i | input | 3 | Per-channel pop request, one word each |
| wr_addr_o | output | 27 | Per-channel SRAM write word address, 9 bits each, channel i at bits [9i+8:9i] |
| rd_addr_o | output | 27 | Per-channel SRAM read word address, same packing |
| level_o | output | 33 | Per-channel level in bytes, 11 bits each, channel i at bits [11i+10:11i] |
| full_o | output | 3 | Per-channel full flag |
| empty_o | output | 3 | Per-channel empty flag |
| ovf_o | output | 3 | Per-channel one-cycle pulse for a rejected push |
| udf_o | output | 3 | Per-channel one-cycle pulse for a rejected pop |

## Verification
A vector table first drives single pushes, single pops, paired push-and-pop and all-channel requests across the three channels at once. This separates correct per-channel decoding from crosstalk between channels, and a correct paired update from a plain increment or decrement.

Directed runs then fill a transmit channel to exactly its region size and then drain it. This shows whether full, wrap-around and empty come at the right word and not one word off. The paired request is applied both at full and at empty, which shows which half of the pair is dropped at each boundary. Mode switches are made with data already queued and a push issued in the transition cycle. These runs tell clearing from retention, and the 192-word merged region from the 96-word one.

// File: rtl/fptr_pkg.sv
package fptr_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL      = 2'd0,
        MODE_TO_MERGED = 2'd1,
        MODE_MERGED    = 2'd2,
        MODE_TO_DUAL   = 2'd3
    } mode_state_e;

    localparam int NUM_CH = 3;
    localparam int CH_RX  = 0;
    localparam int CH_TX0 = 1;
    localparam int CH_TX1 = 2;

endpackage

// File: rtl/fptr_mode_ctl.sv
module fptr_mode_ctl
    import fptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic one_chan_i,
    output logic merged_o,
    output logic flush_o
);

    mode_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_DUAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_DUAL:      if (one_chan_i)  state_d = MODE_TO_MERGED;
            MODE_TO_MERGED:                  state_d = MODE_MERGED;
            MODE_MERGED:    if (!one_chan_i) state_d = MODE_TO_DUAL;
            MODE_TO_DUAL:                    state_d = MODE_DUAL;
            default:                         state_d = MODE_DUAL;
        endcase
    end

    always_comb begin
        merged_o = 1'b0;
        flush_o  = 1'b0;
        unique case (state_q)
            MODE_DUAL:      begin merged_o = 1'b0; flush_o = 1'b0; end
            MODE_TO_MERGED: begin merged_o = 1'b1; flush_o = 1'b1; end
            MODE_MERGED:    begin merged_o = 1'b1; flush_o = 1'b0; end
            MODE_TO_DUAL:   begin merged_o = 1'b0; flush_o = 1'b1; end
            default:        begin merged_o = 1'b0; flush_o = 1'b0; end
        endcase
    end

    // R8: a transition state lasts exactly one cycle
    assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R8: leaving dual mode always lands in merged mode
    assert_enter_merged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_TO_MERGED) |=> (state_q == MODE_MERGED));

endmodule

// File: rtl/fptr_chan.sv
module fptr_chan #(
    parameter int AW   = 9,
    parameter int CW   = 8,
    parameter int BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [AW-1:0] last_i,
    input  logic [CW-1:0] depth_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          udf_o
);

    localparam logic [AW-1:0] BASE_A = AW'(BASE);

    logic [AW-1:0] wptr_q, rptr_q, wptr_n, rptr_n;
    logic [CW-1:0] count_q;
    logic          acc_push, acc_pop;
    logic          ovf_q, udf_q;

    always_comb begin
        full_o   = en_i ? (count_q == depth_i) : 1'b1;
        empty_o  = en_i ? (count_q == '0)      : 1'b1;
        acc_push = push_i && en_i && !clr_i && (count_q != depth_i);
        acc_pop  = pop_i  && en_i && !clr_i && (count_q != '0);
        wptr_n   = (wptr_q == last_i) ? BASE_A : wptr_q + AW'(1);
        rptr_n   = (rptr_q == last_i) ? BASE_A : rptr_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= BASE_A;
            rptr_q  <= BASE_A;
            count_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            ovf_q <= push_i && !clr_i && !acc_push;
            udf_q <= pop_i  && !clr_i && !acc_pop;
            if (clr_i) begin
                wptr_q  <= BASE_A;
                rptr_q  <= BASE_A;
                count_q <= '0;
            end else begin
                if (acc_push) wptr_q <= wptr_n;
                if (acc_pop)  rptr_q <= rptr_n;
                unique case ({acc_push, acc_pop})
                    2'b10:   count_q <= count_q + CW'(1);
                    2'b01:   count_q <= count_q - CW'(1);
                    default: count_q <= count_q;
                endcase
            end
        end
    end

    assign wr_addr_o = wptr_q;
    assign rd_addr_o = rptr_q;
    assign count_o   = count_q;
    assign ovf_o     = ovf_q;
    assign udf_o     = udf_q;

    // R2: an accepted push away from the region end moves one word up
    assert_push_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && en_i && !clr_i && !full_o && wptr_q != last_i)
        |=> (wptr_q == $past(wptr_q) + AW'(1)));

    // R3: the last word of the region is followed by the base
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && en_i && !clr_i && !full_o && wptr_q == last_i)
        |=> (wptr_q == BASE_A));

    // R4: a push alone on a full channel leaves the count alone
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o && !clr_i) |=> (count_q == $past(count_q)));

    // R4: a rejected push is reported the following cycle
    assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !clr_i) |=> ovf_o);

    // R5: a rejected pop is reported the following cycle
    assert_udf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !clr_i) |=> udf_o);

    // R6: a paired push and pop in the middle keeps the count
    assert_pair_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && en_i && !clr_i && !full_o && !empty_o)
        |=> (count_q == $past(count_q)));

endmodule

// File: rtl/fifo_ptr_bank.sv
module fifo_ptr_bank
    import fptr_pkg::*;
#(
    parameter  int RX_WORDS       = 192,
    parameter  int TX_WORDS       = 96,
    parameter  int LIST_COUNT     = 3,
    parameter  int LIST_WORDS     = 16,
    parameter  int BYTES_PER_WORD = 8,
    localparam int NCH            = NUM_CH,
    localparam int LIST_BASE      = RX_WORDS + 2 * TX_WORDS,
    localparam int TOTAL_WORDS    = LIST_BASE + LIST_COUNT * LIST_WORDS,
    localparam int AW             = $clog2(TOTAL_WORDS),
    localparam int MAX_WORDS      = (RX_WORDS > 2 * TX_WORDS) ? RX_WORDS : 2 * TX_WORDS,
    localparam int CW             = $clog2(MAX_WORDS + 1),
    localparam int LW             = CW + $clog2(BYTES_PER_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_chan_i,
    input  logic [NCH-1:0]    push_i,
    input  logic [NCH-1:0]    pop_i,
    output logic [NCH*AW-1:0] wr_addr_o,
    output logic [NCH*AW-1:0] rd_addr_o,
    output logic [NCH*LW-1:0] level_o,
    output logic [NCH-1:0]    full_o,
    output logic [NCH-1:0]    empty_o,
    output logic [NCH-1:0]    ovf_o,
    output logic [NCH-1:0]    udf_o
);

    logic merged, flush;

    fptr_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .one_chan_i (one_chan_i),
        .merged_o   (merged),
        .flush_o    (flush)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int BASE = (i == 0) ? 0 : RX_WORDS + (i - 1) * TX_WORDS;

        logic [AW-1:0] last;
        logic [CW-1:0] depth;
        logic          en, clr;
        logic [CW-1:0] count;
        logic [AW-1:0] wa, ra;

        if (i == CH_RX) begin : g_rx
            assign last  = AW'(RX_WORDS - 1);
            assign depth = CW'(RX_WORDS);
            assign en    = 1'b1;
            assign clr   = 1'b0;
        end else if (i == CH_TX0) begin : g_tx0
            assign last  = merged ? AW'(LIST_BASE - 1) : AW'(BASE + TX_WORDS - 1);
            assign depth = merged ? CW'(2 * TX_WORDS) : CW'(TX_WORDS);
            assign en    = 1'b1;
            assign clr   = flush;
        end else begin : g_tx1
            assign last  = AW'(BASE + TX_WORDS - 1);
            assign depth = CW'(TX_WORDS);
            assign en    = !merged;
            assign clr   = flush;
        end

        fptr_chan #(.AW(AW), .CW(CW), .BASE(BASE)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr),
            .en_i      (en),
            .last_i    (last),
            .depth_i   (depth),
            .push_i    (push_i[i]),
            .pop_i     (pop_i[i]),
            .wr_addr_o (wa),
            .rd_addr_o (ra),
            .count_o   (count),
            .full_o    (full_o[i]),
            .empty_o   (empty_o[i]),
            .ovf_o     (ovf_o[i]),
            .udf_o     (udf_o[i])
        );

        assign wr_addr_o[i*AW +: AW] = wa;
        assign rd_addr_o[i*AW +: AW] = ra;
        assign level_o[i*LW +: LW]   = LW'(count) * LW'(BYTES_PER_WORD);

        // R10: addresses stay below the list area
        assert_list_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wa < AW'(LIST_BASE)) && (ra < AW'(LIST_BASE)));
    end

    // R8: the transition state leaves both transmit channels empty
    assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_o[CH_TX0*LW +: LW] == '0) && (level_o[CH_TX1*LW +: LW] == '0));

endmodule

// File: tb/tb_fifo_ptr_bank.sv
`timescale 1ns/1ps
module tb_fifo_ptr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        one_chan_i = 1'b0;
    logic [2:0]  push_i = '0;
    logic [2:0]  pop_i = '0;
    logic [26:0] wr_addr_o, rd_addr_o;
    logic [32:0] level_o;
    logic [2:0]  full_o, empty_o, ovf_o, udf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fifo_ptr_bank dut (
        .clk(clk), .rst_n(rst_n), .one_chan_i(one_chan_i),
        .push_i(push_i), .pop_i(pop_i),
        .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o), .level_o(level_o),
        .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o), .udf_o(udf_o)
    );

    // Vector: {push[3], pop[3], level rx[11], level tx0[11], level tx1[11], ovf[3], udf[3]}
    localparam int VW = 45;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'b000, 3'b111, 11'd0, 11'd0,  11'd0, 3'b000, 3'b111},
        {3'b111, 3'b000, 11'd8, 11'd8,  11'd8, 3'b000, 3'b000},
        {3'b001, 3'b001, 11'd8, 11'd8,  11'd8, 3'b000, 3'b000},
        {3'b010, 3'b000, 11'd8, 11'd16, 11'd8, 3'b000, 3'b000},
        {3'b000, 3'b100, 11'd8, 11'd16, 11'd0, 3'b000, 3'b000},
        {3'b000, 3'b111, 11'd0, 11'd8,  11'd0, 3'b000, 3'b100},
        {3'b100, 3'b100, 11'd0, 11'd8,  11'd8, 3'b000, 3'b100},
        {3'b000, 3'b010, 11'd0, 11'd0,  11'd8, 3'b000, 3'b000}
    };

    function automatic int lvl(input int ch);
        return int'(level_o[ch*11 +: 11]);
    endfunction
    function automatic int wa(input int ch);
        return int'(wr_addr_o[ch*9 +: 9]);
    endfunction
    function automatic int ra(input int ch);
        return int'(rd_addr_o[ch*9 +: 9]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic [2:0] pu, input logic [2:0] po);
        push_i = pu;
        pop_i  = po;
        @(posedge clk);
        @(negedge clk);
        push_i = '0;
        pop_i  = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        one_chan_i = 1'b0;
        push_i = '0;
        pop_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int c = 0; c < 3; c++) begin
            chk("R1 level", lvl(c), 0);
        end
        chk("R1 empty", int'(empty_o), 7);
        chk("R1 full", int'(full_o), 0);
        chk("R1 errors", int'({ovf_o, udf_o}), 0);
        chk("R1 wr base rx", wa(0), 0);
        chk("R1 wr base tx0", wa(1), 192);
        chk("R1 wr base tx1", wa(2), 288);
        chk("R1 rd base tx1", ra(2), 288);

        // Table: R2 R5 R6 R7 across channels
        for (int v = 0; v < NV; v++) begin
            cyc(VEC[v][44:42], VEC[v][41:39]);
            chk("R2/R7 level rx", lvl(0), int'(VEC[v][38:28]));
            chk("R2/R7 level tx0", lvl(1), int'(VEC[v][27:17]));
            chk("R2/R7 level tx1", lvl(2), int'(VEC[v][16:6]));
            chk("R4 ovf vector", int'(ovf_o), int'(VEC[v][5:3]));
            chk("R5/R6 udf vector", int'(udf_o), int'(VEC[v][2:0]));
        end

        do_reset();
        // R2 single push then pop addresses
        cyc(3'b001, 3'b000);
        chk("R2 wr advance", wa(0), 1);
        cyc(3'b000, 3'b001);
        chk("R2 rd advance", ra(0), 1);

        // R3 R4 fill channel 2
        for (int k = 0; k < 96; k++) cyc(3'b100, 3'b000);
        chk("R4 full level", lvl(2), 768);
        chk("R4 full flag", int'(full_o[2]), 1);
        chk("R3 wr wrap", wa(2), 288);
        cyc(3'b100, 3'b000);
        chk("R4 ovf pulse", int'(ovf_o), 3'b100);
        chk("R4 level held", lvl(2), 768);
        cyc(3'b100, 3'b100);
        chk("R6 full pair level", lvl(2), 760);
        chk("R6 full pair ovf", int'(ovf_o), 3'b100);
        chk("R6 full pair wr", wa(2), 288);
        chk("R6 full pair rd", ra(2), 289);
        for (int k = 0; k < 95; k++) cyc(3'b000, 3'b100);
        chk("R3 rd wrap", ra(2), 288);
        chk("R5 empty flag", int'(empty_o[2]), 1);
        cyc(3'b000, 3'b100);
        chk("R5 udf pulse", int'(udf_o), 3'b100);
        chk("R5 level held", lvl(2), 0);
        cyc(3'b100, 3'b100);
        chk("R6 empty pair level", lvl(2), 8);
        chk("R6 empty pair udf", int'(udf_o), 3'b100);
        chk("R7 rx untouched", lvl(0), 0);
        chk("R7 tx0 untouched", wa(1), 192);

        // R6 paired request in the middle
        cyc(3'b010, 3'b000);
        cyc(3'b010, 3'b000);
        cyc(3'b010, 3'b010);
        chk("R6 mid level", lvl(1), 16);
        chk("R6 mid wr", wa(1), 195);
        chk("R6 mid rd", ra(1), 193);

        // R8 switch to merged with data queued and a push in the transition cycle
        cyc(3'b001, 3'b000);
        one_chan_i = 1'b1;
        cyc(3'b000, 3'b000);
        cyc(3'b010, 3'b000);
        chk("R8 tx0 cleared", lvl(1), 0);
        chk("R8 tx0 wr base", wa(1), 192);
        chk("R8 tx0 rd base", ra(1), 192);
        chk("R8 tx1 cleared", lvl(2), 0);
        chk("R8 rx kept", lvl(0), 8);
        chk("R8 no error", int'({ovf_o, udf_o}), 0);
        chk("R9 tx1 full+empty", int'({full_o[2], empty_o[2]}), 3);

        // R9 merged region size and wrap
        for (int k = 0; k < 192; k++) cyc(3'b010, 3'b000);
        chk("R9 merged level", lvl(1), 1536);
        chk("R9 merged full", int'(full_o[1]), 1);
        chk("R9 merged wrap", wa(1), 192);
        cyc(3'b100, 3'b000);
        chk("R9 tx1 push ovf", int'(ovf_o), 3'b100);
        cyc(3'b000, 3'b100);
        chk("R9 tx1 pop udf", int'(udf_o), 3'b100);
        chk("R9 tx1 level", lvl(2), 0);

        // R8 back to dual
        one_chan_i = 1'b0;
        cyc(3'b000, 3'b000);
        cyc(3'b000, 3'b000);
        chk("R8 dual tx0 level", lvl(1), 0);
        chk("R8 dual tx0 full", int'(full_o[1]), 0);
        chk("R8 dual tx1 flags", int'({full_o[2], empty_o[2]}), 1);
        cyc(3'b100, 3'b000);
        chk("R8 dual tx1 usable", lvl(2), 8);

        finish_run();
    end

endmodule